// File: doc/BRIEF.md
# Pulse-Count Stream Receiver

This block recovers 16-bit words from a single wire on which the sender encodes every value as a number of pulses. It needs no clock or data recovery. The line is first brought into the local clock domain, and the block counts each rising edge it sees. A burst of pulses forms one stream. A stream ends when the line has stayed low for a programmable gap of clock cycles.

A packet holds six streams, in this order:
- a start stream that also carries the combined segment flags;
- four sub-segment streams;
- a stop stream.

Each stream is worth its pulse count minus one, except the stop stream. The four sub-segments form two encoded bytes. Each byte is restored by optionally undoing a bit-order reversal and then optionally undoing a bitwise inversion, as its 2-bit mode selects.

A complete, well-formed packet yields the restored word together with a single-cycle valid strobe. A malformed packet yields a single-cycle error strobe instead. In that case the word is dropped, and the block again waits for a start stream.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While `rst_ni` is low and after its release, `word_o` is 0 and both `valid_o` and `err_o` are 0.
- R2: Each stream's value is its number of rising edges on `line_i` minus one. Both high time and low spacing are irrelevant as long as each low spacing inside the stream is shorter than `GAP_CYC`.
- R3: A low period of `GAP_CYC` (default 4) cycles or more ends a stream. A low period of `GAP_CYC-1` cycles between pulses keeps them in the same stream.
- R4: The first stream gives a 4-bit flag. Bits 3:2 are the mode of the low byte and bits 1:0 are the mode of the high byte. In a mode, bit 0 set means the byte is bit-reversed first, and bit 1 set means the result is then inverted.
- R5: Sub-segment streams SS0..SS3 arrive in that order. The low byte is {SS1,SS0} before decoding and forms `word_o[7:0]`. The high byte is {SS3,SS2} and forms `word_o[15:8]`.
- R6: `valid_o` pulses for exactly one cycle, and only after a stop stream of exactly 2 pulses. `word_o` changes only in that cycle and holds afterwards.
- R7: A stop stream of any count other than 2 gives a one-cycle `err_o`, no `valid_o`, and leaves `word_o` unchanged.
- R8: A flag stream or a sub-segment stream of more than 16 pulses gives a one-cycle `err_o` right at that stream's end. The block then treats the next stream as a new start stream, so a following good packet decodes correctly.
- R9: `valid_o` and `err_o` are never high in the same cycle.
- R10: A line held low produces neither strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous single-wire pulse input |
| word_o | output | 16 | Last correctly decoded word |
| valid_o | output | 1 | One-cycle strobe: new word on `word_o` |
| err_o | output | 1 | One-cycle strobe: packet rejected |

## Verification
A wrong internal state shows up at the ports within about eight cycles of the stop stream's trailing gap:
- A miscounted edge or a misjudged gap shifts a stream value. It can also slip the stream index, so the following streams land in the wrong slots. At the ports this appears either as a wrong word or as an error strobe in place of a valid strobe.
- A mode bit applied to the wrong byte, or an undo step taken in the wrong order, corrupts only the affected byte.

The near-exhaustive sweeps are built to isolate both kinds of fault. One sweep covers every low-byte value, and another covers every flag combination on a fixed word.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int SEG_W     = 4;
  localparam int SS_PER_DS = 2;
  localparam int DS_N      = 2;
  localparam int SS_N      = DS_N * SS_PER_DS;
  localparam int BYTE_W    = SEG_W * SS_PER_DS;
  localparam int WORD_W    = BYTE_W * DS_N;
  localparam int MODE_W    = 2;
  localparam int FLG_W     = MODE_W * DS_N;
  localparam int STOP_CNT  = 2;

  typedef enum logic [1:0] {ST_FLG, ST_SS, ST_STOP} rx_st_e;
endpackage

// File: rtl/pcs_rx_sync.sv
module pcs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pcs_rx_stream.sv
module pcs_rx_stream #(
  parameter int GAP_CYC = 4,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int LOW_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active_q, done_q;
  logic [LOW_W-1:0] low_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      low_q    <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        active_q <= 1'b1;
        low_q    <= '0;
        if (!active_q)             cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1; // saturate
      end else if (active_q && !lvl_i) begin
        if (low_q == LOW_W'(GAP_CYC - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          low_q    <= '0;
        end else begin
          low_q <= low_q + 1'b1;
        end
      end else if (lvl_i) begin
        low_q <= '0;
      end
    end
  end

  assign done_o = done_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pcs_rx_unmap.sv
module pcs_rx_unmap
  import pcs_rx_pkg::*;
(
  input  logic [FLG_W-1:0]           flags_i,
  input  logic [SS_N-1:0][SEG_W-1:0] ss_i,
  output logic [WORD_W-1:0]          word_o
);
  for (genvar d = 0; d < DS_N; d++) begin : g_seg
    logic [BYTE_W-1:0] enc, unrev;
    logic [MODE_W-1:0] mode;

    assign enc  = ss_i[d*SS_PER_DS +: SS_PER_DS];
    assign mode = flags_i[FLG_W-1-d*MODE_W -: MODE_W];

    always_comb begin
      for (int i = 0; i < BYTE_W; i++)
        unrev[i] = mode[0] ? enc[BYTE_W-1-i] : enc[i];
    end

    assign word_o[d*BYTE_W +: BYTE_W] = mode[1] ? ~unrev : unrev;
  end
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcs_rx_pkg::*;
#(
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int IX_W = $clog2(SS_N);
  localparam logic [CNT_W-1:0] SS_LIM  = CNT_W'(2 ** SEG_W);
  localparam logic [CNT_W-1:0] FLG_LIM = CNT_W'(2 ** FLG_W);
  localparam logic [CNT_W-1:0] STOP_N  = CNT_W'(STOP_CNT);

  logic             lvl, rise, strm_done;
  logic [CNT_W-1:0] strm_cnt, strm_val;

  pcs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .lvl_o(lvl), .rise_o(rise)
  );

  pcs_rx_stream #(.GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_i(rise),
    .done_o(strm_done), .cnt_o(strm_cnt)
  );

  rx_st_e                     st_q;
  logic [IX_W-1:0]            ix_q;
  logic [FLG_W-1:0]           flags_q;
  logic [SS_N-1:0][SEG_W-1:0] ss_q;
  logic [WORD_W-1:0]          dec_word, word_q;
  logic                       valid_q, err_q;

  assign strm_val = strm_cnt - 1'b1;

  pcs_rx_unmap u_unmap (.flags_i(flags_q), .ss_i(ss_q), .word_o(dec_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FLG;
      ix_q    <= '0;
      flags_q <= '0;
      ss_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (strm_done) begin
        unique case (st_q)
          ST_FLG: begin
            if (strm_cnt > FLG_LIM) begin
              err_q <= 1'b1;
            end else begin
              flags_q <= strm_val[FLG_W-1:0];
              ix_q    <= '0;
              st_q    <= ST_SS;
            end
          end
          ST_SS: begin
            if (strm_cnt > SS_LIM) begin
              err_q <= 1'b1;
              st_q  <= ST_FLG;
            end else begin
              ss_q[ix_q] <= strm_val[SEG_W-1:0];
              ix_q       <= ix_q + 1'b1;
              if (ix_q == IX_W'(SS_N - 1)) st_q <= ST_STOP;
            end
          end
          default: begin
            if (strm_cnt == STOP_N) begin
              valid_q <= 1'b1;
              word_q  <= dec_word;
            end else begin
              err_q <= 1'b1;
            end
            st_q <= ST_FLG;
          end
        endcase
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pcs_rx_decoder_chk.sv
module pcs_rx_decoder_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o,
  input logic              err_o,
  input logic              strm_done,
  input logic [CNT_W-1:0]  strm_cnt
);
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_word_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  assert_valid_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strm_done && strm_cnt == CNT_W'(2)));

  assert_err_at_stream_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(strm_done));
endmodule

bind pcs_rx_decoder pcs_rx_decoder_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_o(word_o), .valid_o(valid_o),
  .err_o(err_o), .strm_done(strm_done), .strm_cnt(strm_cnt)
);

// File: tb/sim_pcs_rx_decoder.sv
module sim_pcs_rx_decoder;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic [15:0] word;
  logic        valid, err;

  int n_chk = 0, n_bad = 0;
  int v_cnt = 0, e_cnt = 0, both_cnt = 0;
  int v_base = 0, e_base = 0;
  logic [15:0] w_base;

  always #10 clk = ~clk;

  pcs_rx_decoder #(.GAP_CYC(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .word_o(word), .valid_o(valid), .err_o(err)
  );

  always @(negedge clk) if (rst_n) begin
    if (valid) v_cnt++;
    if (err) e_cnt++;
    if (valid && err) both_cnt++;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic logic [1:0] best_mode(input logic [7:0] b);
    logic inv; logic [7:0] v;
    inv = $countones(b) > 4;
    v = inv ? ~b : b;
    return {inv, rev8(v) < v};
  endfunction

  // inversion first, then reversal; the receiver undoes them in reverse order
  function automatic logic [7:0] apply_mode(input logic [7:0] b, input logic [1:0] m);
    logic [7:0] v;
    v = m[1] ? ~b : b;
    return m[0] ? rev8(v) : v;
  endfunction

  task automatic mark();
    v_base = v_cnt; e_base = e_cnt; w_base = word;
  endtask

  task automatic send_stream(input int n, input int space);
    for (int i = 0; i < n; i++) begin
      line = 1'b1; @(negedge clk);
      line = 1'b0;
      repeat (space) @(negedge clk);
    end
    repeat (GAP + 2) @(negedge clk);
  endtask

  task automatic send_counts(input int f, input int s0, input int s1,
                             input int s2, input int s3, input int stp, input int space);
    send_stream(f, space);
    send_stream(s0, space); send_stream(s1, space);
    send_stream(s2, space); send_stream(s3, space);
    send_stream(stp, space);
  endtask

  task automatic send_word(input logic [15:0] d, input logic [1:0] m0,
                           input logic [1:0] m1, input int space);
    logic [7:0] e0, e1;
    e0 = apply_mode(d[7:0], m0);
    e1 = apply_mode(d[15:8], m1);
    send_counts(int'({m0, m1}) + 1, int'(e0[3:0]) + 1, int'(e0[7:4]) + 1,
                int'(e1[3:0]) + 1, int'(e1[7:4]) + 1, 2, space);
  endtask

  task automatic expect_pkt(input string tag, input int dv, input int de,
                            input logic [15:0] w);
    repeat (8) @(negedge clk);
    n_chk++;
    if (v_cnt - v_base != dv || e_cnt - e_base != de || word !== w) begin
      n_bad++;
      $display("FAIL %s: valid=%0d err=%0d word=%h, expected valid=%0d err=%0d word=%h",
               tag, v_cnt - v_base, e_cnt - e_base, word, dv, de, w);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    n_chk++;
    if (word !== 16'h0 || valid !== 1'b0 || err !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: word=%h valid=%b err=%b, expected 0 0 0", word, valid, err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mark();
    repeat (50) @(negedge clk);
    expect_pkt("R1 R10 idle line", 0, 0, 16'h0);

    // R4: hand-built counts 15,8,1,2,1 give 0xFE1F
    mark(); send_counts(15, 8, 1, 2, 1, 2, 1);
    expect_pkt("R4 R5 fixed counts", 1, 0, 16'hFE1F);

    // R2 R5: every low-byte value, encoded as a sender would
    for (int a = 0; a < 256; a++) begin
      d = {8'(a) ^ 8'h5A, 8'(a)};
      mark(); send_word(d, best_mode(d[7:0]), best_mode(d[15:8]), 1);
      expect_pkt("R2 R5 byte sweep", 1, 0, d);
    end

    // R4: every flag combination on one word
    for (int m = 0; m < 16; m++) begin
      mark(); send_word(16'h3C96, 2'(m >> 2), 2'(m), 1);
      expect_pkt("R4 flag sweep", 1, 0, 16'h3C96);
    end

    // extremes: all streams at maximum legal count
    mark(); send_word(16'h0000, 2'b11, 2'b11, 1);
    expect_pkt("R2 R4 all-zero word", 1, 0, 16'h0000);
    mark(); send_counts(16, 16, 16, 16, 16, 2, 1);
    expect_pkt("R2 R8 max counts accepted", 1, 0, 16'h0000);
    mark(); send_word(16'hFFFF, 2'b00, 2'b00, 1);
    expect_pkt("R2 all-one word", 1, 0, 16'hFFFF);

    // R3: spacing of GAP-1 low cycles stays inside a stream
    mark(); send_word(16'hA55A, 2'b01, 2'b10, GAP - 1);
    expect_pkt("R3 long in-stream spacing", 1, 0, 16'hA55A);

    // R7: bad stop counts
    mark(); send_counts(1, 2, 3, 4, 5, 3, 1);
    expect_pkt("R7 stop of 3", 0, 1, w_base);
    mark(); send_counts(1, 2, 3, 4, 5, 1, 1);
    expect_pkt("R7 stop of 1", 0, 1, w_base);

    // R8: overlong flag stream, then overlong sub-segment, then recovery
    mark(); send_stream(17, 1);
    expect_pkt("R8 flag count 17", 0, 1, w_base);
    mark(); send_stream(1, 1); send_stream(17, 1);
    expect_pkt("R8 sub-segment count 17", 0, 1, w_base);
    mark(); send_word(16'h1234, 2'b00, 2'b01, 1);
    expect_pkt("R8 recovery packet", 1, 0, 16'h1234);

    n_chk++;
    if (both_cnt != 0) begin
      n_bad++;
      $display("FAIL R9: %0d cycles with valid and err together, expected 0", both_cnt);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule